// File: doc/BRIEF.md
# Four-Operand Lane-Splittable Adder with Logic Mode

This block is the post-multiplier stage of an arithmetic slice. Each accepted item carries a product word, a split A/B operand, a C word, a carry bit and four control words. Four operand selectors, named W, X, Y and Z, pick from the product, the A:B concatenation, C, the previous result (P) and constants. An arithmetic function then forms Z plus or minus the sum of W, X, Y and a selected carry-in. The 58-bit result lands in a registered P output. A lane setting cuts the adder into two 24-bit or four 12-bit lanes, and each lane gives its own carry-out. The same datapath also serves as a 58-bit bitwise logic unit.

Items enter and leave on valid/ready streams. An item is taken on a clock edge where `in_valid` and `in_ready` are both high. It passes through an input register and then the P register. While `out_valid` is high and `out_ready` is low, the output holds steady and `in_ready` stays low, so the whole two-stage pipe stalls as one. The previous result stays in P across idle cycles, so accumulation works across gaps in the input stream. With `CTRL_REG` set (the default), the control words are registered together with the data, so each item runs under its own controls. With `CTRL_REG` cleared, the live control pins act on whatever item sits in the input register.

Top module: `quad_lane_alu`

## Requirements
- R1: While `rst` is high, and after it is released with no input, `out_valid` is 0, `p_out` is 0, `carry_out` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. An item accepted at edge E with no stall shows `out_valid` after edge E+1. A stalled output keeps its value. Results leave in acceptance order, one per accepted item.
- R3: The selectors are decoded from `opmode` as follows. X is bits [1:0]: 0 gives zero, 1 the product, 2 P, 3 {A,B}. Y is bits [3:2]: 2 gives all ones, 3 gives C, 0 and 1 give zero. Z is bits [6:4]: 1 gives P, 2 gives C, all other codes give zero. W is bits [8:7]: 1 gives P, 2 gives C, 0 and 3 give zero.
- R4: When `alumode[3:2]` is not 01 the block does arithmetic modulo 2^58. With `alumode[1:0]`=11 it computes Z-(W+X+Y+cin), with 01 it computes (W+X+Y+cin)-Z, and with any other value Z+W+X+Y+cin. In one-lane mode `carry_out[0]` is bit 58 of that computation and the other carry bits are 0.
- R5: `cin_sel` picks the carry-in. 0 gives `carry_in`, 1 gives P[57], 2 gives the inverse of P[57], 3 gives C[57], and 4 to 7 give 0. P here is the previous result.
- R6: P feedback always holds the most recent result, including after idle cycles, so repeated Z=P items accumulate.
- R7: `lane_cfg`=1 selects two lanes, bits [23:0] and [47:24]. Each lane is computed on its own and gives its carry (bit 24 of the lane computation) on `carry_out[0]` and `carry_out[1]`. The carry-in enters only the low lane. Bits 57:48 of P are 0 and `carry_out[3:2]` is 0.
- R8: `lane_cfg`=2 selects four 12-bit lanes starting at bits 0, 12, 24 and 36. Their carries (bit 12 of each lane computation) appear on `carry_out[3:0]`, lowest lane on bit 0. Bits 57:48 are 0 and the carry-in enters lane 0 only. `lane_cfg`=3 acts as one lane.
- R9: In either split mode, an X selection of the product contributes zero.
- R10: When `alumode[3:2]`=01 the block runs as a bitwise logic unit on X and Z. `alumode[1:0]` picks the function: 00 gives X^Z, 01 gives X&Z, 10 gives X|Z and 11 gives ~X. The output is inverted when Y select is 2 (this yields XNOR, NAND, NOR and plain X). W, the carry-in and `lane_cfg` are ignored, and `carry_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Input item accepted when high with in_valid |
| prod_in | input | 58 | Product operand |
| a_in | input | 34 | Upper part of the A:B operand |
| b_in | input | 24 | Lower part of the A:B operand |
| c_in | input | 58 | C operand |
| carry_in | input | 1 | External carry-in |
| opmode | input | 9 | W/Z/Y/X selector codes |
| alumode | input | 4 | Arithmetic or logic function |
| cin_sel | input | 3 | Carry-in source select |
| lane_cfg | input | 2 | Lane split: 0 one, 1 two, 2 four |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| p_out | output | 58 | Registered result |
| carry_out | output | 4 | Per-lane carry-outs |

## Verification
A broken lane cut would let a carry cross into the next lane. That shows on the first split-mode result as a lane value that is off by one, or as a wrong carry bit. A corrupted P register does not stay hidden for long. It shows directly, and it also spreads into every later item that selects P, either as an operand or as the source of the carry-in. A fault in the stall logic shows in the same cycle: the output changes, or `in_ready` rises, while the output is held back.

// File: rtl/qla_pkg.sv
package qla_pkg;
  localparam int OPM_W  = 9;
  localparam int ALU_W  = 4;
  localparam int CSEL_W = 3;
  localparam int CFG_W  = 2;

  typedef enum logic [1:0] {
    LANES_ONE  = 2'd0,
    LANES_TWO  = 2'd1,
    LANES_FOUR = 2'd2,
    LANES_RSVD = 2'd3
  } lane_cfg_e;

  typedef enum logic [1:0] {
    ARITH_ADD  = 2'd0,
    ARITH_SUB  = 2'd1,
    ARITH_RSUB = 2'd2
  } arith_op_e;

  typedef enum logic [1:0] {
    LF_XOR  = 2'd0,
    LF_AND  = 2'd1,
    LF_OR   = 2'd2,
    LF_NOTX = 2'd3
  } logic_fn_e;

  typedef struct packed {
    logic [OPM_W-1:0]  opmode;
    logic [ALU_W-1:0]  alumode;
    logic [CSEL_W-1:0] cin_sel;
    lane_cfg_e         lanes;
  } ctrl_t;
endpackage

// File: rtl/qla_operand_mux.sv
module qla_operand_mux
  import qla_pkg::*;
#(
  parameter int DW = 58,
  parameter int AW = 34
) (
  input  logic [DW-1:0]    prod,
  input  logic [AW-1:0]    a,
  input  logic [DW-AW-1:0] b,
  input  logic [DW-1:0]    c,
  input  logic [DW-1:0]    p,
  input  logic [OPM_W-1:0] opmode,
  input  logic             simd,
  output logic [DW-1:0]    w,
  output logic [DW-1:0]    x,
  output logic [DW-1:0]    y,
  output logic [DW-1:0]    z
);
  // R3 selector decode; R9 product blocked in split modes
  always_comb begin
    case (opmode[1:0])
      2'd1:    x = simd ? '0 : prod;
      2'd2:    x = p;
      2'd3:    x = {a, b};
      default: x = '0;
    endcase
    case (opmode[3:2])
      2'd2:    y = '1;
      2'd3:    y = c;
      default: y = '0;
    endcase
    case (opmode[6:4])
      3'd1:    z = p;
      3'd2:    z = c;
      default: z = '0;
    endcase
    case (opmode[8:7])
      2'd1:    w = p;
      2'd2:    w = c;
      default: w = '0;
    endcase
  end
endmodule

// File: rtl/qla_lane_adder.sv
module qla_lane_adder
  import qla_pkg::*;
#(
  parameter int LW = 12
) (
  input  logic [LW-1:0] w,
  input  logic [LW-1:0] x,
  input  logic [LW-1:0] y,
  input  logic [LW-1:0] z,
  input  logic          cin,
  input  arith_op_e     op,
  output logic [LW-1:0] res,
  output logic          cout
);
  localparam int EW = LW + 1;

  logic [EW-1:0] opsum;
  logic [EW-1:0] full;

  // one bit above the lane is enough to expose the lane carry (R4, R7, R8)
  always_comb begin
    opsum = EW'(w) + EW'(x) + EW'(y) + EW'(cin);
    case (op)
      ARITH_SUB:  full = EW'(z) - opsum;
      ARITH_RSUB: full = opsum - EW'(z);
      default:    full = EW'(z) + opsum;
    endcase
  end

  assign res  = full[LW-1:0];
  assign cout = full[LW];
endmodule

// File: rtl/qla_simd_adder.sv
module qla_simd_adder
  import qla_pkg::*;
#(
  parameter int DW   = 58,
  parameter int SPAN = 48,
  parameter int QW   = 12,
  parameter int HW   = 24
) (
  input  logic [DW-1:0]      w,
  input  logic [DW-1:0]      x,
  input  logic [DW-1:0]      y,
  input  logic [DW-1:0]      z,
  input  logic               cin,
  input  arith_op_e          op,
  input  lane_cfg_e          lanes,
  output logic [DW-1:0]      sum,
  output logic [SPAN/QW-1:0] carry
);
  localparam int NQ  = SPAN / QW;
  localparam int NH  = SPAN / HW;
  localparam int PAD = DW - SPAN;

  logic [DW-1:0]   one_res;
  logic            one_c;
  logic [SPAN-1:0] half_res;
  logic [NH-1:0]   half_c;
  logic [SPAN-1:0] quad_res;
  logic [NQ-1:0]   quad_c;

  qla_lane_adder #(.LW(DW)) u_one (
    .w(w), .x(x), .y(y), .z(z), .cin(cin), .op(op),
    .res(one_res), .cout(one_c)
  );

  // R7: two lanes, carry-in to the lowest only
  for (genvar i = 0; i < NH; i++) begin : g_half
    qla_lane_adder #(.LW(HW)) u_lane (
      .w(w[i*HW +: HW]), .x(x[i*HW +: HW]), .y(y[i*HW +: HW]), .z(z[i*HW +: HW]),
      .cin((i == 0) ? cin : 1'b0), .op(op),
      .res(half_res[i*HW +: HW]), .cout(half_c[i])
    );
  end

  // R8: four lanes
  for (genvar i = 0; i < NQ; i++) begin : g_quad
    qla_lane_adder #(.LW(QW)) u_lane (
      .w(w[i*QW +: QW]), .x(x[i*QW +: QW]), .y(y[i*QW +: QW]), .z(z[i*QW +: QW]),
      .cin((i == 0) ? cin : 1'b0), .op(op),
      .res(quad_res[i*QW +: QW]), .cout(quad_c[i])
    );
  end

  always_comb begin
    carry = '0;
    case (lanes)
      LANES_TWO: begin
        sum            = {{PAD{1'b0}}, half_res};
        carry[NH-1:0]  = half_c;
      end
      LANES_FOUR: begin
        sum   = {{PAD{1'b0}}, quad_res};
        carry = quad_c;
      end
      default: begin
        sum      = one_res;
        carry[0] = one_c;
      end
    endcase
  end
endmodule

// File: rtl/qla_logic_unit.sv
module qla_logic_unit
  import qla_pkg::*;
#(
  parameter int DW = 58
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] z,
  input  logic_fn_e     fn,
  input  logic          invert,
  output logic [DW-1:0] res
);
  logic [DW-1:0] base;

  // R10
  always_comb begin
    case (fn)
      LF_AND:  base = x & z;
      LF_OR:   base = x | z;
      LF_NOTX: base = ~x;
      default: base = x ^ z;
    endcase
    res = invert ? ~base : base;
  end
endmodule

// File: rtl/quad_lane_alu.sv
module quad_lane_alu
  import qla_pkg::*;
#(
  parameter int DW       = 58,
  parameter int AW       = 34,
  parameter int SPAN     = 48,
  parameter int QW       = 12,
  parameter int HW       = 24,
  parameter bit CTRL_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DW-1:0]        prod_in,
  input  logic [AW-1:0]        a_in,
  input  logic [DW-AW-1:0]     b_in,
  input  logic [DW-1:0]        c_in,
  input  logic                 carry_in,
  input  logic [OPM_W-1:0]     opmode,
  input  logic [ALU_W-1:0]     alumode,
  input  logic [CSEL_W-1:0]    cin_sel,
  input  logic [CFG_W-1:0]     lane_cfg,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DW-1:0]        p_out,
  output logic [SPAN/QW-1:0]   carry_out
);
  localparam int BW = DW - AW;
  localparam int NQ = SPAN / QW;
  localparam int NH = SPAN / HW;

  // stage 1: input register
  logic          s1_valid;
  logic [DW-1:0] prod_q, c_q;
  logic [AW-1:0] a_q;
  logic [BW-1:0] b_q;
  logic          cin_q;
  ctrl_t         ctrl_in, ctrl_use;

  // stage 2: result register
  logic          p_valid;
  logic [DW-1:0] p_q;
  logic [NQ-1:0] carry_q;

  logic adv, fire;

  assign adv      = !p_valid || out_ready;   // R2
  assign in_ready = adv;
  assign fire     = adv && s1_valid;

  assign ctrl_in = '{opmode: opmode, alumode: alumode, cin_sel: cin_sel,
                     lanes: lane_cfg_e'(lane_cfg)};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      prod_q   <= '0;
      a_q      <= '0;
      b_q      <= '0;
      c_q      <= '0;
      cin_q    <= 1'b0;
    end else if (adv) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        prod_q <= prod_in;
        a_q    <= a_in;
        b_q    <= b_in;
        c_q    <= c_in;
        cin_q  <= carry_in;
      end
    end
  end

  if (CTRL_REG) begin : g_ctrl_reg
    ctrl_t ctrl_q;
    always_ff @(posedge clk) begin
      if (rst) ctrl_q <= '0;
      else if (adv && in_valid) ctrl_q <= ctrl_in;
    end
    assign ctrl_use = ctrl_q;
  end else begin : g_ctrl_live
    assign ctrl_use = ctrl_in;
  end

  // decode
  logic      simd_mode, logic_mode, cin_sel_bit, invert;
  arith_op_e aop;
  logic_fn_e lfn;

  assign simd_mode  = (ctrl_use.lanes == LANES_TWO) || (ctrl_use.lanes == LANES_FOUR);
  assign logic_mode = (ctrl_use.alumode[3:2] == 2'b01);
  assign invert     = (ctrl_use.opmode[3:2] == 2'b10);
  assign lfn        = logic_fn_e'(ctrl_use.alumode[1:0]);

  always_comb begin
    case (ctrl_use.alumode[1:0])
      2'b11:   aop = ARITH_SUB;
      2'b01:   aop = ARITH_RSUB;
      default: aop = ARITH_ADD;
    endcase
    // R5 carry-in source
    case (ctrl_use.cin_sel)
      3'd0:    cin_sel_bit = cin_q;
      3'd1:    cin_sel_bit = p_q[DW-1];
      3'd2:    cin_sel_bit = ~p_q[DW-1];
      3'd3:    cin_sel_bit = c_q[DW-1];
      default: cin_sel_bit = 1'b0;
    endcase
  end

  logic [DW-1:0] w_op, x_op, y_op, z_op, add_sum, lu_res, res_d;
  logic [NQ-1:0] add_carry, carry_d;

  qla_operand_mux #(.DW(DW), .AW(AW)) u_mux (
    .prod(prod_q), .a(a_q), .b(b_q), .c(c_q), .p(p_q),
    .opmode(ctrl_use.opmode), .simd(simd_mode),
    .w(w_op), .x(x_op), .y(y_op), .z(z_op)
  );

  qla_simd_adder #(.DW(DW), .SPAN(SPAN), .QW(QW), .HW(HW)) u_add (
    .w(w_op), .x(x_op), .y(y_op), .z(z_op), .cin(cin_sel_bit),
    .op(aop), .lanes(ctrl_use.lanes), .sum(add_sum), .carry(add_carry)
  );

  qla_logic_unit #(.DW(DW)) u_lu (
    .x(x_op), .z(z_op), .fn(lfn), .invert(invert), .res(lu_res)
  );

  assign res_d   = logic_mode ? lu_res : add_sum;
  assign carry_d = logic_mode ? '0 : add_carry;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid <= 1'b0;
      p_q     <= '0;
      carry_q <= '0;
    end else begin
      if (adv) p_valid <= s1_valid;
      if (fire) begin
        p_q     <= res_d;     // R6: held until the next item
        carry_q <= carry_d;
      end
    end
  end

  assign out_valid = p_valid;
  assign p_out     = p_q;
  assign carry_out = carry_q;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!p_valid && p_q == '0 && carry_q == '0)); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (p_valid && !out_ready) |=> (p_valid && $stable(p_q) && $stable(carry_q))); // R2
  AST_ITEM_ISSUED: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && in_ready) |=> p_valid); // R2
  AST_ONE_LANE_CARRY: assert property (@(posedge clk) disable iff (rst)
    $past(fire && !simd_mode && !logic_mode) |-> (carry_q[NQ-1:1] == '0)); // R4
  AST_SPLIT_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(fire && simd_mode && !logic_mode) |-> (p_q[DW-1:SPAN] == '0)); // R7
  AST_HALF_CARRY: assert property (@(posedge clk) disable iff (rst)
    $past(fire && ctrl_use.lanes == LANES_TWO && !logic_mode) |-> (carry_q[NQ-1:NH] == '0)); // R7
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    $past(fire && logic_mode) |-> (carry_q == '0)); // R10
endmodule

// File: tb/tb_quad_lane_alu.sv
module tb_quad_lane_alu;
  localparam int DW = 58;
  localparam int AW = 34;
  localparam int BW = 24;
  localparam int NQ = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] prod_in = '0, c_in = '0;
  logic [AW-1:0] a_in = '0;
  logic [BW-1:0] b_in = '0;
  logic          carry_in = 1'b0;
  logic [8:0]    opmode = '0;
  logic [3:0]    alumode = '0;
  logic [2:0]    cin_sel = '0;
  logic [1:0]    lane_cfg = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] p_out;
  logic [NQ-1:0] carry_out;

  quad_lane_alu dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .prod_in(prod_in), .a_in(a_in), .b_in(b_in), .c_in(c_in), .carry_in(carry_in),
    .opmode(opmode), .alumode(alumode), .cin_sel(cin_sel), .lane_cfg(lane_cfg),
    .out_valid(out_valid), .out_ready(out_ready), .p_out(p_out), .carry_out(carry_out)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit bp_on  = 1'b0;
  bit done   = 1'b0;
  logic [DW-1:0] p_model = '0;
  logic [DW-1:0] q_p[$];
  logic [NQ-1:0] q_c[$];
  string         q_tag[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] opm(input int w, input int z, input int y, input int x);
    return {2'(w), 3'(z), 2'(y), 2'(x)};
  endfunction

  function automatic logic [DW+NQ-1:0] model(
    input logic [DW-1:0] pr, input logic [AW-1:0] a, input logic [BW-1:0] b,
    input logic [DW-1:0] c, input logic ci, input logic [8:0] op,
    input logic [3:0] alu, input logic [2:0] cs, input logic [1:0] cfg,
    input logic [DW-1:0] p);
    logic [63:0] xv, yv, zv, wv, res, mask, s, r;
    logic [NQ-1:0] cy;
    logic cin;
    int nl, lw;
    bit split;
    split = (cfg == 2'd1) || (cfg == 2'd2);
    case (op[1:0])
      2'd1: xv = split ? 64'd0 : 64'(pr);
      2'd2: xv = 64'(p);
      2'd3: xv = 64'({a, b});
      default: xv = 64'd0;
    endcase
    case (op[3:2])
      2'd2: yv = 64'({DW{1'b1}});
      2'd3: yv = 64'(c);
      default: yv = 64'd0;
    endcase
    case (op[6:4])
      3'd1: zv = 64'(p);
      3'd2: zv = 64'(c);
      default: zv = 64'd0;
    endcase
    case (op[8:7])
      2'd1: wv = 64'(p);
      2'd2: wv = 64'(c);
      default: wv = 64'd0;
    endcase
    case (cs)
      3'd0: cin = ci;
      3'd1: cin = p[DW-1];
      3'd2: cin = ~p[DW-1];
      3'd3: cin = c[DW-1];
      default: cin = 1'b0;
    endcase
    cy = '0;
    res = 64'd0;
    if (alu[3:2] == 2'b01) begin
      case (alu[1:0])
        2'b00: res = xv ^ zv;
        2'b01: res = xv & zv;
        2'b10: res = xv | zv;
        default: res = ~xv;
      endcase
      if (op[3:2] == 2'd2) res = ~res;
    end else begin
      if (cfg == 2'd1) begin nl = 2; lw = 24; end
      else if (cfg == 2'd2) begin nl = 4; lw = 12; end
      else begin nl = 1; lw = DW; end
      mask = (64'd1 << lw) - 64'd1;
      for (int i = 0; i < nl; i++) begin
        s = ((wv >> (i*lw)) & mask) + ((xv >> (i*lw)) & mask) + ((yv >> (i*lw)) & mask)
            + ((i == 0) ? 64'(cin) : 64'd0);
        if (alu[1:0] == 2'b11)      r = ((zv >> (i*lw)) & mask) - s;
        else if (alu[1:0] == 2'b01) r = s - ((zv >> (i*lw)) & mask);
        else                        r = ((zv >> (i*lw)) & mask) + s;
        res   = res | ((r & mask) << (i*lw));
        cy[i] = r[lw];
      end
    end
    return {cy, res[DW-1:0]};
  endfunction

  task automatic send(input logic [DW-1:0] pr, input logic [AW-1:0] a, input logic [BW-1:0] b,
                      input logic [DW-1:0] c, input logic ci, input logic [8:0] op,
                      input logic [3:0] alu, input logic [2:0] cs, input logic [1:0] cfg,
                      input string tag);
    logic [DW+NQ-1:0] e;
    @(negedge clk);
    prod_in = pr; a_in = a; b_in = b; c_in = c; carry_in = ci;
    opmode = op; alumode = alu; cin_sel = cs; lane_cfg = cfg;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    e = model(pr, a, b, c, ci, op, alu, cs, cfg, p_model);
    q_p.push_back(e[DW-1:0]);
    q_c.push_back(e[DW+NQ-1:DW]);
    q_tag.push_back(tag);
    p_model = e[DW-1:0];
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_p.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // monitor / scoreboard
  bit            stall_prev = 1'b0;
  logic [DW-1:0] stall_p;
  initial begin
    forever begin
      @(negedge clk);
      out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (!rst) begin
        if (stall_prev)
          check(out_valid && p_out == stall_p, "R2", "output held while stalled", 64'(p_out), 64'(stall_p));
        if (out_valid && !out_ready) begin
          check(!in_ready, "R2", "in_ready low while stalled", 64'(in_ready), 64'd0);
          stall_prev = 1'b1;
          stall_p    = p_out;
        end else begin
          stall_prev = 1'b0;
        end
        if (out_valid && out_ready) begin
          if (q_p.size() == 0) begin
            check(1'b0, "R2", "unexpected output", 64'(p_out), 64'd0);
          end else begin
            logic [DW-1:0] ep;
            logic [NQ-1:0] ec;
            string         tg;
            ep = q_p.pop_front();
            ec = q_c.pop_front();
            tg = q_tag.pop_front();
            check(p_out == ep, tg, "p_out", 64'(p_out), 64'(ep));
            check(carry_out == ec, tg, "carry_out", 64'(carry_out), 64'(ec));
          end
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid, "R1", "out_valid during reset", 64'(out_valid), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    check(p_out == '0, "R1", "p_out after reset", 64'(p_out), 64'd0);
    check(carry_out == '0, "R1", "carry_out after reset", 64'(carry_out), 64'd0);
    check(in_ready, "R1", "in_ready after reset", 64'(in_ready), 64'd1);

    // R2 latency
    send('0, 34'd5, 24'd7, '0, 1'b0, opm(0,0,0,3), 4'b0000, 3'd0, 2'd0, "R2");
    @(negedge clk); #1;
    check(!out_valid, "R2", "no output one edge after accept", 64'(out_valid), 64'd0);
    @(negedge clk); #1;
    check(out_valid, "R2", "output two edges after accept", 64'(out_valid), 64'd1);
    drain();

    // R3 selectors
    send(58'h123456789ABCDEF, 34'h3_0000_0001, 24'hABCDEF, 58'h5, 1'b0, opm(0,0,0,3), 4'b0000, 3'd0, 2'd0, "R3");
    send(58'h123456789ABCDEF, 34'h1, 24'h2, 58'h5, 1'b0, opm(0,0,0,1), 4'b0000, 3'd0, 2'd0, "R3");
    send('0, 34'h0, 24'h0, 58'h1111, 1'b0, opm(2,2,3,0), 4'b0000, 3'd0, 2'd0, "R3");
    send('0, 34'h0, 24'h10, '0, 1'b0, opm(0,0,2,3), 4'b0000, 3'd0, 2'd0, "R3");
    send('0, 34'h0, 24'h10, 58'h77, 1'b0, opm(3,5,1,3), 4'b0000, 3'd0, 2'd0, "R3");
    send('0, 34'h0, 24'h10, 58'h77, 1'b0, opm(1,1,0,2), 4'b0000, 3'd0, 2'd0, "R3");

    // R4 arithmetic
    send('0, 34'h0, 24'h30, 58'h100, 1'b0, opm(0,2,0,3), 4'b0011, 3'd0, 2'd0, "R4");
    send('0, 34'h0, 24'h30, 58'h100, 1'b0, opm(0,2,0,3), 4'b0001, 3'd0, 2'd0, "R4");
    send('0, 34'h0, 24'h1, ONES, 1'b0, opm(0,2,0,3), 4'b0000, 3'd0, 2'd0, "R4");
    send('0, 34'h0, 24'h9, 58'h4, 1'b1, opm(0,2,0,3), 4'b1010, 3'd0, 2'd0, "R4");

    // R5 carry-in sources
    send('0, 34'h0, 24'h0, ONES, 1'b1, opm(0,2,0,0), 4'b0000, 3'd0, 2'd0, "R5");
    for (int k = 1; k < 8; k++)
      send('0, 34'h0, 24'h2, {1'b1, 57'h3}, 1'b1, opm(0,2,0,3), 4'b0000, 3'(k), 2'd0, "R5");

    // R6 accumulation across gaps
    send('0, 34'h0, 24'h0, '0, 1'b0, opm(0,0,0,0), 4'b0000, 3'd0, 2'd0, "R6");
    for (int k = 0; k < 3; k++)
      send('0, 34'h0, 24'h100 + 24'(k), '0, 1'b0, opm(0,1,0,3), 4'b0000, 3'd0, 2'd0, "R6");
    drain();
    repeat (5) @(negedge clk);
    send('0, 34'h0, 24'h5, '0, 1'b0, opm(0,1,0,3), 4'b0000, 3'd0, 2'd0, "R6");
    send('0, 34'h0, 24'h5, '0, 1'b0, opm(1,1,0,0), 4'b0011, 3'd0, 2'd0, "R6");

    // R7 two lanes
    send('0, 34'h3_FFFF_FFFF, 24'hFFFFFF, 58'h0_0001_000001, 1'b1, opm(0,2,0,3), 4'b0000, 3'd0, 2'd1, "R7");
    send('0, 34'h1_0000_0002, 24'h000003, 58'h0_0005_000001, 1'b0, opm(0,2,0,3), 4'b0011, 3'd0, 2'd1, "R7");

    // R8 four lanes, R9 product blocked
    send('0, 34'h0_0FFF_0FF, 24'hFFF001, 58'h1_0001_0010_0FFF, 1'b1, opm(0,2,0,3), 4'b0000, 3'd0, 2'd2, "R8");
    send('0, 34'h0_0002_003, 24'h004005, 58'h0_0001_0001_0001, 1'b0, opm(0,2,0,3), 4'b0011, 3'd0, 2'd2, "R8");
    send('0, 34'h0_0002_003, 24'h004005, 58'h0_0001_0001_0001, 1'b0, opm(0,2,0,3), 4'b0000, 3'd0, 2'd3, "R8");
    send(58'h0FFF_FFFF_FFFF, 34'h0, 24'h0, 58'h3, 1'b0, opm(0,2,0,1), 4'b0000, 3'd0, 2'd2, "R9");
    send(58'h0FFF_FFFF_FFFF, 34'h0, 24'h0, 58'h3, 1'b0, opm(0,2,0,1), 4'b0000, 3'd0, 2'd1, "R9");

    // R10 logic functions, plain and inverted
    for (int f = 0; f < 4; f++) begin
      send('0, 34'h2_5A5A_F0F0, 24'h00FF33, 58'h0F0F_0F0F_0F0F, 1'b1, opm(2,2,0,3), 4'(4 + f), 3'd0, 2'd2, "R10");
      send('0, 34'h2_5A5A_F0F0, 24'h00FF33, 58'h0F0F_0F0F_0F0F, 1'b1, opm(2,2,2,3), 4'(4 + f), 3'd0, 2'd1, "R10");
    end
    drain();

    // mixed traffic under back-pressure
    bp_on = 1'b1;
    for (int k = 0; k < 80; k++)
      send({$urandom, $urandom}, {$urandom, $urandom}, 24'($urandom), {$urandom, $urandom},
           1'($urandom), 9'($urandom), 4'($urandom), 3'($urandom), 2'($urandom), "R2");
    drain();
    bp_on = 1'b0;
    repeat (3) @(negedge clk);
    check(q_p.size() == 0, "R2", "all results delivered", 64'(q_p.size()), 64'd0);
    done = 1'b1;
    finish_run();
  end
endmodule